// File: doc/BRIEF.md
# Bit-Time Configuration and Quantum Sequencer

This block sits at the front of a serial bus controller's bit engine. Software programs two 8-bit timing registers: one holds the quantum prescaler and a jump-width field, the other holds the two phase-segment lengths and the sample-mode selector. It can only do this while the controller is held in software initialization. When software releases initialization, the staged values are copied into a working set. The bit engine then runs from that working set, so it never sees a half-written configuration.

From the working set the block divides the system clock into time quanta and counts quanta into bit periods. It emits three strobes. A quantum tick marks the last clock of each quantum. A bit-start strobe marks the first clock of each bit. Sample strobes mark the sample point, plus two earlier quanta when three-sample mode is chosen. Software cannot release initialization while both segment fields are zero, because that would give a degenerate bit.

Top module: `bit_timing_unit`

## Requirements
- R1: After reset the block is in initialization (`init_mode`=1), every working field reads zero, and `tq_tick`, `bit_start` and `sample_stb` are low.
- R2: A write with `wr_sel`=0 stages the prescaler from `wr_data[5:0]` and the jump width from `wr_data[7:6]`. A write with `wr_sel`=1 stages segment 1 from `wr_data[3:0]`, segment 2 from `wr_data[6:4]` and three-sample mode from `wr_data[7]`.
- R3: A register write is discarded when `init_mode`=0 or when `bus_off`=1. The working values taken at the next release show no trace of it.
- R4: The working set is replaced by the staged set only on the clock where an init write with value 0 finds `init_mode`=1 and is accepted. At all other times the working outputs hold.
- R5: A release request is refused while both staged segment fields are zero. `init_mode` stays 1 and the working set is unchanged. An init write with value 1 always enters initialization.
- R6: While running (`init_mode`=0), `tq_tick` is high on the last clock of every quantum, and a quantum lasts prescaler+1 clocks.
- R7: A bit lasts 3+seg1+seg2 quanta. `bit_start` is high on the first clock of quantum 0, which is the first clock after the release.
- R8: `sample_stb` is high together with the tick that ends quantum seg1+1, the last quantum of segment 1.
- R9: In three-sample mode, `sample_stb` is also high on the ticks ending quanta seg1 and seg1-1, where those quanta exist (index 0 or higher).
- R10: While `init_mode`=1 all three strobes stay low. After each release the sequence restarts from quantum 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Timing register write strobe |
| wr_sel | input | 1 | 0: prescaler register, 1: segment register |
| wr_data | input | 8 | Write data |
| init_wr_en | input | 1 | Write strobe for the initialization bit |
| init_wr_val | input | 1 | Value written to the initialization bit |
| bus_off | input | 1 | Controller is in bus-off |
| init_mode | output | 1 | Initialization bit state |
| act_presc | output | 6 | Working prescaler |
| act_jump | output | 2 | Working jump width |
| act_seg1 | output | 4 | Working segment 1 field |
| act_seg2 | output | 3 | Working segment 2 field |
| act_triple | output | 1 | Working three-sample mode |
| tq_tick | output | 1 | Last clock of a quantum |
| bit_start | output | 1 | First clock of a bit |
| sample_stb | output | 1 | Sample point strobe |

## Verification
The strobe sequence is tried with a fast configuration (prescaler 0, single-clock quanta) and with a mid-range one. This tells a quantum-length error apart from a quantum-count error. A maximal configuration checks for counter wrap problems. Three-sample mode runs once with segment 1 large and once with segment 1 zero. The second run shows whether the extra strobes are correctly left out of quanta that do not exist. Writes made while running, writes made during bus-off and an exit attempt with zero segments each end with a legal release. The working outputs then show whether the refused action left any trace.

// File: rtl/btu_pkg.sv
// Package: shared constants and the register select encoding for the
// bit-time configuration unit. Assumes 8-bit software registers.
package btu_pkg;
    localparam int REG_W = 8;

    typedef enum logic {
        SEL_PRESC = 1'b0,
        SEL_SEG   = 1'b1
    } btu_sel_e;
endpackage

// File: rtl/bt_cfg_regs.sv
// Module: bt_cfg_regs
// Holds the staged timing registers behind the initialization gate. It also
// holds the initialization bit and the working copy. Assumes one write port.
// Assumes the working copy is taken from the staged values as they stood
// before the clock of an accepted release.
module bt_cfg_regs
    import btu_pkg::*;
#(
    parameter int PRESC_W = 6,
    parameter int SEG1_W  = 4,
    parameter int SEG2_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               init_wr_en,
    input  logic               init_wr_val,
    input  logic               bus_off,
    output logic               init_q,
    output logic [PRESC_W-1:0] work_presc,
    output logic [REG_W-PRESC_W-1:0] work_jump,
    output logic [SEG1_W-1:0]  work_seg1,
    output logic [SEG2_W-1:0]  work_seg2,
    output logic               work_triple
);
    localparam int S2_LO = SEG1_W;
    localparam int S2_HI = SEG1_W + SEG2_W - 1;

    logic [REG_W-1:0] stage_a, stage_b;
    logic [REG_W-1:0] work_a, work_b;
    logic             wr_ok, exit_req, exit_ok, seg_zero;

    // Gate and release decisions.
    always_comb begin
        wr_ok    = init_q && !bus_off;
        seg_zero = (stage_b[SEG1_W-1:0] == '0) && (stage_b[S2_HI:S2_LO] == '0);
        exit_req = init_wr_en && !init_wr_val && init_q;
        exit_ok  = exit_req && !seg_zero;
    end

    // Staged registers: accept software writes only when writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_a <= '0;
            stage_b <= '0;
        end else if (wr_en && wr_ok) begin
            if (btu_sel_e'(wr_sel) == SEL_SEG) stage_b <= wr_data;
            else                               stage_a <= wr_data;
        end
    end

    // Initialization bit: a set is always accepted, a clear only when legal.
    always_ff @(posedge clk) begin
        if (!rst_n)                       init_q <= 1'b1;
        else if (init_wr_en && init_wr_val) init_q <= 1'b1;
        else if (exit_ok)                 init_q <= 1'b0;
    end

    // Working copy: loaded on an accepted release only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_a <= '0;
            work_b <= '0;
        end else if (exit_ok) begin
            work_a <= stage_a;
            work_b <= stage_b;
        end
    end

    // Field extraction from the working copy.
    always_comb begin
        work_presc  = work_a[PRESC_W-1:0];
        work_jump   = work_a[REG_W-1:PRESC_W];
        work_seg1   = work_b[SEG1_W-1:0];
        work_seg2   = work_b[S2_HI:S2_LO];
        work_triple = work_b[REG_W-1];
    end

    assert_stage_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q || bus_off) |=> ($stable(stage_a) && $stable(stage_b)))
        else $error("staged register changed while locked");

    assert_work_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_q && init_wr_en && !init_wr_val) |=> ($stable(work_a) && $stable(work_b)))
        else $error("working copy changed without a release");

    assert_exit_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && init_wr_en && !init_wr_val && seg_zero) |=> init_q)
        else $error("release accepted with zero segments");
endmodule

// File: rtl/bt_quantum.sv
// Module: bt_quantum
// Divides the system clock into time quanta of presc+1 clocks. Assumes presc
// is constant while run is high. The counter is held at zero while not running.
module bt_quantum #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tq_tick,
    output logic               q_first
);
    logic [PRESC_W-1:0] pc;

    // Prescaler counter: counts 0..presc, then wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pc <= '0;
        else if (pc == presc) pc <= '0;
        else                pc <= pc + PRESC_W'(1);
    end

    // Quantum boundary decode.
    always_comb begin
        tq_tick = run && (pc == presc);
        q_first = run && (pc == '0);
    end

    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && presc != '0 && run) |=> !tq_tick)
        else $error("quantum ticks too close");
endmodule

// File: rtl/bt_segseq.sv
// Module: bt_segseq
// Counts quanta through sync, segment 1 and segment 2. It decodes the
// bit-start and sample strobes. Assumes the segment fields are constant
// while run is high.
module bt_segseq #(
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tq_tick,
    input  logic              q_first,
    input  logic [SEG1_W-1:0] seg1,
    input  logic [SEG2_W-1:0] seg2,
    input  logic              triple,
    output logic              bit_start,
    output logic              sample_stb
);
    localparam int QW = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 2;

    logic [QW-1:0] q_idx, q_last, s1_ext;
    logic          hit_main, hit_pre1, hit_pre2;

    // Bit length and sample point positions.
    always_comb begin
        s1_ext   = QW'(seg1);
        q_last   = QW'(2) + s1_ext + QW'(seg2);
        hit_main = (q_idx == s1_ext + QW'(1));
        hit_pre1 = triple && (q_idx == s1_ext);
        hit_pre2 = triple && (q_idx + QW'(1) == s1_ext);
    end

    // Quantum index within the bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  q_idx <= '0;
        else if (tq_tick) begin
            if (q_idx == q_last) q_idx <= '0;
            else                 q_idx <= q_idx + QW'(1);
        end
    end

    // Strobe decode.
    always_comb begin
        bit_start  = q_first && (q_idx == '0);
        sample_stb = tq_tick && (hit_main || hit_pre1 || hit_pre2);
    end

    assert_index_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q_idx <= q_last))
        else $error("quantum index beyond bit end");

    assert_bit_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && q_idx == q_last && run) |=> (bit_start || !run))
        else $error("no bit start after last quantum");
endmodule

// File: rtl/bit_timing_unit.sv
// Module: bit_timing_unit (top)
// Connects the configuration gate, the quantum divider and the segment
// sequencer. The generator runs only while initialization is released.
module bit_timing_unit
    import btu_pkg::*;
#(
    parameter int PRESC_W = 6,
    parameter int SEG1_W  = 4,
    parameter int SEG2_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [7:0]         wr_data,
    input  logic               init_wr_en,
    input  logic               init_wr_val,
    input  logic               bus_off,
    output logic               init_mode,
    output logic [PRESC_W-1:0] act_presc,
    output logic [7-PRESC_W:0] act_jump,
    output logic [SEG1_W-1:0]  act_seg1,
    output logic [SEG2_W-1:0]  act_seg2,
    output logic               act_triple,
    output logic               tq_tick,
    output logic               bit_start,
    output logic               sample_stb
);
    logic run, q_first;

    // Generator enable follows the released initialization bit.
    always_comb run = !init_mode;

    bt_cfg_regs #(.PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .init_wr_en(init_wr_en), .init_wr_val(init_wr_val),
        .bus_off(bus_off), .init_q(init_mode), .work_presc(act_presc),
        .work_jump(act_jump), .work_seg1(act_seg1), .work_seg2(act_seg2),
        .work_triple(act_triple)
    );

    bt_quantum #(.PRESC_W(PRESC_W)) u_quantum (
        .clk(clk), .rst_n(rst_n), .run(run), .presc(act_presc),
        .tq_tick(tq_tick), .q_first(q_first)
    );

    bt_segseq #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick),
        .q_first(q_first), .seg1(act_seg1), .seg2(act_seg2),
        .triple(act_triple), .bit_start(bit_start), .sample_stb(sample_stb)
    );

    assert_idle_in_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |-> (!tq_tick && !bit_start && !sample_stb))
        else $error("strobe while in initialization");
endmodule

// File: tb/tb_bit_timing_unit.sv
`timescale 1ns/1ps
module tb_bit_timing_unit;
    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, init_wr_en = 0, init_wr_val = 0, bus_off = 0;
    logic [7:0] wr_data = '0;
    logic init_mode, act_triple, tq_tick, bit_start, sample_stb;
    logic [5:0] act_presc;
    logic [1:0] act_jump;
    logic [3:0] act_seg1;
    logic [2:0] act_seg2;

    int checks = 0, errors = 0;
    bit done = 0, cmp_on = 0;

    // Reference model state.
    int m_init = 1, st_a = 0, st_b = 0, wk_a = 0, wk_b = 0, cyc = 0;

    always #2.5 clk = ~clk;

    bit_timing_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .init_wr_en(init_wr_en), .init_wr_val(init_wr_val), .bus_off(bus_off),
        .init_mode(init_mode), .act_presc(act_presc), .act_jump(act_jump),
        .act_seg1(act_seg1), .act_seg2(act_seg2), .act_triple(act_triple),
        .tq_tick(tq_tick), .bit_start(bit_start), .sample_stb(sample_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update at each active edge.
    always @(posedge clk) begin
        int old_a, old_b, n;
        if (!rst_n) begin
            m_init = 1; st_a = 0; st_b = 0; wk_a = 0; wk_b = 0; cyc = 0;
        end else begin
            old_a = st_a; old_b = st_b;
            if (!m_init) begin
                n = ((wk_a & 63) + 1) * (3 + (wk_b & 15) + ((wk_b >> 4) & 7));
                cyc = (cyc + 1) % n;
            end
            if (wr_en && m_init && !bus_off) begin
                if (wr_sel) st_b = wr_data; else st_a = wr_data;
            end
            if (init_wr_en) begin
                if (init_wr_val) begin
                    m_init = 1; cyc = 0;
                end else if (m_init && ((old_b & 8'h7f) != 0)) begin
                    m_init = 0; wk_a = old_a; wk_b = old_b; cyc = 0;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        int p, s1, s2, t, pc, q, e_tq, e_bs, e_sm;
        if (cmp_on) begin
            p = wk_a & 63; s1 = wk_b & 15; s2 = (wk_b >> 4) & 7; t = (wk_b >> 7) & 1;
            e_tq = 0; e_bs = 0; e_sm = 0;
            if (!m_init) begin
                pc = cyc % (p + 1); q = cyc / (p + 1);
                e_tq = (pc == p);
                e_bs = (cyc == 0);
                e_sm = e_tq && ((q == s1 + 1) || (t == 1 && (q == s1 || q == s1 - 1)));
            end
            chk("R5 init_mode", int'(init_mode), m_init);
            chk("R4 act_presc", int'(act_presc), p);
            chk("R2 act_jump", int'(act_jump), (wk_a >> 6) & 3);
            chk("R4 act_seg1", int'(act_seg1), s1);
            chk("R2 act_seg2", int'(act_seg2), s2);
            chk("R9 act_triple", int'(act_triple), t);
            chk("R6 tq_tick", int'(tq_tick), e_tq);
            chk("R7 bit_start", int'(bit_start), e_bs);
            chk("R8 sample_stb", int'(sample_stb), e_sm);
        end
    end

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic set_init(input logic v);
        @(negedge clk); init_wr_en = 1; init_wr_val = v;
        @(negedge clk); init_wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 init after reset", int'(init_mode), 1);
        chk("R1 presc after reset", int'(act_presc), 0);
        chk("R1 strobes after reset", int'({tq_tick, bit_start, sample_stb}), 0);
        cmp_on = 1;
        // R2/R6/R7/R8: mid-range configuration
        wr_reg(0, 8'h82);              // presc 2, jump 2
        wr_reg(1, 8'h23);              // seg1 3, seg2 2
        set_init(0);
        idle(80);
        chk("R4 loaded presc", int'(act_presc), 2);
        // R3: writes while running are dropped
        wr_reg(1, 8'h7f);
        idle(20);
        set_init(1);
        idle(3);
        // R10: strobes idle in init
        chk("R10 idle tick", int'(tq_tick), 0);
        // R3: bus-off blocks writes
        bus_off = 1;
        wr_reg(0, 8'h05);
        bus_off = 0;
        set_init(0);
        idle(40);
        chk("R3 presc kept", int'(act_presc), 2);
        chk("R3 seg1 kept", int'(act_seg1), 3);
        // R5: refused release with both segments zero
        set_init(1);
        wr_reg(1, 8'h80);
        set_init(0);
        idle(5);
        chk("R5 stays in init", int'(init_mode), 1);
        chk("R5 working kept", int'(act_seg1), 3);
        // R9: three-sample mode, single-clock quanta
        wr_reg(0, 8'h00);
        wr_reg(1, 8'h94);              // triple, seg2 1, seg1 4
        set_init(0);
        idle(60);
        // R9: seg1 zero, extra strobe only on quantum 0
        set_init(1);
        wr_reg(0, 8'h01);
        wr_reg(1, 8'h90);              // triple, seg2 1, seg1 0
        set_init(0);
        idle(40);
        // R6/R7: maximal configuration
        set_init(1);
        wr_reg(0, 8'h3f);
        wr_reg(1, 8'h7f);
        set_init(0);
        idle(1700);
        chk("R7 max seg2", int'(act_seg2), 7);
        set_init(1);
        idle(4);
        done = 1;
        summary();
        $finish;
    end
endmodule